// File: doc/BRIEF.md
# Sound RAM Transfer Staging Engine

This block carries 16-bit halfwords between a host and a local sound sample RAM through a 32-entry staging FIFO. The host pushes data through a 16-bit manual data register or a 32-bit DMA word port, and reads data back through the DMA word port. A pacing engine moves one halfword between the FIFO and the RAM per fixed slot of 32 clock cycles. Request flags tell the DMA controller when a whole FIFO of read data is ready, or when the FIFO has fully drained and can take a new burst.

A mode register selects the direction of transfer. In both write modes the engine drains the FIFO into RAM. In the DMA read mode it fills the FIFO from RAM. In the stopped mode it holds still. The RAM sits outside the block on a single-port interface. It takes a halfword-aligned byte address and returns read data one cycle after the enable, holding that data until the next access.

Top module: `snd_xfer_engine`

## Requirements
- R1: The FIFO holds exactly DEPTH (32) halfwords. It returns them oldest first.
- R2: In DMA write mode (mode code 2), dma_wr_req_o and dma_req_o are high exactly when the FIFO is empty.
- R3: In stopped mode (code 0) and manual write mode (code 1), dma_rd_req_o, dma_wr_req_o and dma_req_o are all low. This holds even when the FIFO contains data.
- R4: The engine completes one FIFO-to-RAM or RAM-to-FIFO halfword every HW_CYCLES (32) cycles. A cycle with a host FIFO access (manual write, DMA write or DMA read) stalls the engine for that cycle.
- R5: In DMA read mode (code 3) the engine fills the FIFO from RAM at ascending addresses and stops when the FIFO is full. In both write modes it pops the FIFO into RAM until the FIFO is empty. In DMA read mode, dma_rd_req_o and dma_req_o are high exactly when the FIFO is full.
- R6: busy_o is high while RAM work is pending: in read mode when the FIFO is not full, and in a write mode when it is not empty. Otherwise busy_o is low.
- R7: A mode write that switches to stopped from any other mode empties the FIFO and resets the read pad value to zero. A write of stopped while already stopped changes nothing.
- R8: A manual data write pushes one halfword. The write is dropped if the FIFO is full.
- R9: A DMA write word is pushed as bits [15:0] first, then bits [31:16]. Halfwords that do not fit in the free space are discarded.
- R10: A DMA read word holds the oldest FIFO halfword in bits [15:0] and the next one in bits [31:16]. If the FIFO runs short, the missing halves repeat the last halfword delivered, or zero if none has been delivered since reset or the last stop.
- R11: The transfer address is a byte address. It advances by 2 per RAM access and wraps at 2^AW bytes (512 KiB), and bit 0 is forced to zero. A load takes effect at the next RAM access. A read that has already been issued completes at the old address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Mode register write strobe |
| ctrl_mode_i | input | 2 | Mode: 0 stopped, 1 manual write, 2 DMA write, 3 DMA read |
| addr_we_i | input | 1 | Transfer address load strobe |
| addr_i | input | AW | Transfer byte address to load |
| man_we_i | input | 1 | Manual data write strobe |
| man_data_i | input | 16 | Manual halfword |
| dma_wr_i | input | 1 | DMA word write strobe |
| dma_wdata_i | input | 32 | DMA write word |
| dma_rd_i | input | 1 | DMA word read strobe (pops on the clock edge) |
| dma_rdata_o | output | 32 | DMA read word, valid while dma_rd_i is high |
| dma_rd_req_o | output | 1 | DMA read request |
| dma_wr_req_o | output | 1 | DMA write request |
| dma_req_o | output | 1 | Combined DMA request |
| busy_o | output | 1 | Transfer engine has RAM work pending |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | AW | RAM byte address |
| ram_wdata_o | output | 16 | RAM write data |
| ram_rdata_i | input | 16 | RAM read data, one cycle after the enable |

## Verification
The bench overfills the FIFO with DMA words and then with a manual write. A design with an off-by-one capacity, or one that lets the dropped halfword wrap over the head, returns the wrong read sequence. It drains the FIFO past empty with one, then zero, entries left. A wrong pad rule shows up as a stale or zero upper half, and a design that fails to clear the pad on stop shows a leftover value. It abandons a manual transfer by stopping, which exposes any FIFO left uncleared: an unexpected RAM write or a missing write request. It drains across the top of the address space, reloads the address between two writes, and times the fill and drain slots. Wrong wrap or reload handling lands halfwords at the wrong addresses, and a wrong slot count changes the measured spacing.

// File: rtl/snd_xfer_pkg.sv
package snd_xfer_pkg;
  typedef enum logic [1:0] {
    XM_STOP   = 2'd0,
    XM_MANUAL = 2'd1,
    XM_DMA_WR = 2'd2,
    XM_DMA_RD = 2'd3
  } xfer_mode_e;
endpackage

// File: rtl/xfer_fifo.sv
// Dual-entry push/pop staging FIFO; DEPTH must be a power of two.
module xfer_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic [1:0]          push_n_i,
  input  logic [1:0][W-1:0]   push_d_i,
  input  logic [1:0]          pop_n_i,
  output logic [CW-1:0]       count_o,
  output logic [1:0][W-1:0]   peek_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!clr_i) begin
      if (push_n_i != 2'd0) mem_q[wr_q] <= push_d_i[0];
      if (push_n_i == 2'd2) mem_q[wr_q + PW'(1)] <= push_d_i[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_q + PW'(push_n_i);
      rd_q  <= rd_q + PW'(pop_n_i);
      cnt_q <= cnt_q + CW'(push_n_i) - CW'(pop_n_i);
    end
  end

  assign count_o   = cnt_q;
  assign peek_o[0] = mem_q[rd_q];
  assign peek_o[1] = mem_q[rd_q + PW'(1)];

  // R1
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R1
  no_underrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> CW'(pop_n_i) <= cnt_q);
  // R1
  no_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> CW'(push_n_i) <= CW'(DEPTH) - cnt_q);
endmodule

// File: rtl/xfer_pacer.sv
// Slot counter: one RAM move per HW_CYCLES cycles; read issued one cycle early.
module xfer_pacer #(
  parameter int HW_CYCLES = 32,
  localparam int CNTW     = $clog2(HW_CYCLES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic hold_i,
  input  logic restart_i,
  output logic issue_o,
  output logic step_o
);
  localparam logic [CNTW-1:0] LAST  = CNTW'(HW_CYCLES - 1);
  localparam logic [CNTW-1:0] ISSUE = CNTW'(HW_CYCLES - 2);

  logic [CNTW-1:0] cnt_q;
  logic            adv;

  assign adv = run_i && !hold_i && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (restart_i || !run_i)  cnt_q <= '0;
    else if (!hold_i)              cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNTW'(1);
  end

  assign issue_o = adv && (cnt_q == ISSUE);
  assign step_o  = adv && (cnt_q == LAST);

  // R4
  slot_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> (cnt_q == '0));
endmodule

// File: rtl/snd_xfer_engine.sv
module snd_xfer_engine
  import snd_xfer_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int HW_CYCLES = 32,
  parameter int AW        = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic [1:0]    ctrl_mode_i,
  input  logic          addr_we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          man_we_i,
  input  logic [15:0]   man_data_i,
  input  logic          dma_wr_i,
  input  logic [31:0]   dma_wdata_i,
  input  logic          dma_rd_i,
  output logic [31:0]   dma_rdata_o,
  output logic          dma_rd_req_o,
  output logic          dma_wr_req_o,
  output logic          dma_req_o,
  output logic          busy_o,
  output logic          ram_en_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [15:0]   ram_wdata_o,
  input  logic [15:0]   ram_rdata_i
);
  localparam int HW = 16;
  localparam int CW = $clog2(DEPTH + 1);

  xfer_mode_e       mode_q;
  logic [AW-1:0]    addr_q;
  logic [HW-1:0]    pad_q;
  logic [CW-1:0]    fifo_cnt, space;
  logic [1:0][HW-1:0] peek, push_d;
  logic [1:0]       push_n, pop_n;
  logic full, empty, rd_mode, wr_mode, host_act, stop_clr, mode_chg;
  logic issue, step, rd_issue, wr_step, rd_step;

  assign full     = (fifo_cnt == CW'(DEPTH));
  assign empty    = (fifo_cnt == '0);
  assign space    = CW'(DEPTH) - fifo_cnt;
  assign rd_mode  = (mode_q == XM_DMA_RD);
  assign wr_mode  = (mode_q == XM_DMA_WR) || (mode_q == XM_MANUAL);
  assign host_act = man_we_i || dma_wr_i || dma_rd_i;
  assign mode_chg = ctrl_we_i && (xfer_mode_e'(ctrl_mode_i) != mode_q);
  assign stop_clr = mode_chg && (xfer_mode_e'(ctrl_mode_i) == XM_STOP);
  assign busy_o   = (rd_mode && !full) || (wr_mode && !empty);

  xfer_pacer #(.HW_CYCLES(HW_CYCLES)) u_pacer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy_o),
    .hold_i    (host_act),
    .restart_i (mode_chg),
    .issue_o   (issue),
    .step_o    (step)
  );

  assign rd_issue = issue && rd_mode;
  assign rd_step  = step && rd_mode;
  assign wr_step  = step && wr_mode;

  // Host accesses own the FIFO in their cycle; the engine only steps when idle.
  always_comb begin
    push_n = 2'd0;
    pop_n  = 2'd0;
    push_d = '0;
    if (stop_clr) begin
      push_n = 2'd0;
    end else if (dma_rd_i) begin
      pop_n = (fifo_cnt >= CW'(2)) ? 2'd2 : 2'(fifo_cnt);
    end else if (dma_wr_i) begin
      push_d[0] = dma_wdata_i[15:0];
      push_d[1] = dma_wdata_i[31:16];
      push_n    = (space >= CW'(2)) ? 2'd2 : 2'(space);
    end else if (man_we_i) begin
      push_d[0] = man_data_i;
      push_n    = full ? 2'd0 : 2'd1;
    end else if (rd_step && !full) begin
      push_d[0] = ram_rdata_i;
      push_n    = 2'd1;
    end else if (wr_step) begin
      pop_n = 2'd1;
    end
  end

  xfer_fifo #(.DEPTH(DEPTH), .W(HW)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (stop_clr),
    .push_n_i (push_n),
    .push_d_i (push_d),
    .pop_n_i  (pop_n),
    .count_o  (fifo_cnt),
    .peek_o   (peek)
  );

  always_comb begin
    if (fifo_cnt >= CW'(2))      dma_rdata_o = {peek[1], peek[0]};
    else if (fifo_cnt == CW'(1)) dma_rdata_o = {peek[0], peek[0]};
    else                         dma_rdata_o = {pad_q, pad_q};
  end

  assign ram_en_o    = rd_issue || wr_step;
  assign ram_we_o    = wr_step;
  assign ram_addr_o  = addr_q;
  assign ram_wdata_o = peek[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= XM_STOP;
      addr_q <= '0;
      pad_q  <= '0;
    end else begin
      if (ctrl_we_i) mode_q <= xfer_mode_e'(ctrl_mode_i);
      if (addr_we_i)     addr_q <= {addr_i[AW-1:1], 1'b0};
      else if (ram_en_o) addr_q <= addr_q + AW'(2);
      if (stop_clr)      pad_q <= '0;
      else if (dma_rd_i) pad_q <= dma_rdata_o[31:16];
    end
  end

  assign dma_rd_req_o = rd_mode && full;
  assign dma_wr_req_o = (mode_q == XM_DMA_WR) && empty;
  assign dma_req_o    = dma_rd_req_o || dma_wr_req_o;

  // R7
  stop_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_clr |=> (fifo_cnt == '0) && !busy_o);
  // R11
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_en_o && !addr_we_i) |=> (ram_addr_o == $past(ram_addr_o) + AW'(2)));
  // R8
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (man_we_i && !dma_rd_i && !dma_wr_i && !ctrl_we_i && full) |=> full);
  // R5
  stopped_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == XM_STOP) |-> !ram_en_o);
  // R3
  idle_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == XM_STOP || mode_q == XM_MANUAL) |-> !dma_req_o);
endmodule

// File: tb/snd_xfer_engine_bench.sv
module snd_xfer_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 0, addr_we = 0, man_we = 0, dma_wr = 0, dma_rd = 0;
  logic [1:0] ctrl_mode = 0;
  logic [AW-1:0] addr = 0;
  logic [15:0] man_data = 0;
  logic [31:0] dma_wdata = 0;
  logic [31:0] dma_rdata;
  logic rd_req, wr_req, req, busy, ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [15:0] ram_wdata;
  logic [15:0] ram_rdata = 0;

  logic [15:0] mem [int];
  logic [31:0] rd_exp_q [$];
  logic [34:0] wr_exp_q [$];
  int wr_cyc_q [$];
  int cyc = 0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snd_xfer_engine u_snd_xfer_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_mode_i(ctrl_mode),
    .addr_we_i(addr_we), .addr_i(addr),
    .man_we_i(man_we), .man_data_i(man_data),
    .dma_wr_i(dma_wr), .dma_wdata_i(dma_wdata),
    .dma_rd_i(dma_rd), .dma_rdata_o(dma_rdata),
    .dma_rd_req_o(rd_req), .dma_wr_req_o(wr_req), .dma_req_o(req),
    .busy_o(busy), .ram_en_o(ram_en), .ram_we_o(ram_we),
    .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
  );

  // behavioural RAM, one-cycle read latency, data held
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ram_en) begin
      if (ram_we) mem[int'(ram_addr)] = ram_wdata;
      else ram_rdata <= mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 16'h0;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // monitor: compares scoreboard items away from the clock edge
  always @(negedge clk) begin
    if (rst_n && dma_rd) begin
      if (rd_exp_q.size() == 0) chk(0, "R10 unexpected read", 64'(dma_rdata), 0);
      else begin
        logic [31:0] e;
        e = rd_exp_q.pop_front();
        chk(dma_rdata == e, "R10 read word", 64'(dma_rdata), 64'(e));
      end
    end
    if (rst_n && ram_en && ram_we) begin
      wr_cyc_q.push_back(cyc);
      if (wr_exp_q.size() == 0) chk(0, "R5 unexpected RAM write", 64'({ram_addr, ram_wdata}), 0);
      else begin
        logic [34:0] e;
        e = wr_exp_q.pop_front();
        chk({ram_addr, ram_wdata} == e, "R11 RAM write addr/data", 64'({ram_addr, ram_wdata}), 64'(e));
      end
    end
  end

  task automatic set_mode(input logic [1:0] m);
    @(posedge clk); #1; ctrl_we = 1; ctrl_mode = m;
    @(posedge clk); #1; ctrl_we = 0;
  endtask
  task automatic set_addr(input logic [AW-1:0] a);
    @(posedge clk); #1; addr_we = 1; addr = a;
    @(posedge clk); #1; addr_we = 0;
  endtask
  task automatic man_write(input logic [15:0] d);
    @(posedge clk); #1; man_we = 1; man_data = d;
    @(posedge clk); #1; man_we = 0;
  endtask
  task automatic dma_write(input logic [31:0] w);
    @(posedge clk); #1; dma_wr = 1; dma_wdata = w;
    @(posedge clk); #1; dma_wr = 0;
  endtask
  task automatic dma_read(input logic [31:0] e);
    rd_exp_q.push_back(e);
    @(posedge clk); #1; dma_rd = 1;
    @(posedge clk); #1; dma_rd = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    int start;
    int el;
    #(CLK_PERIOD * 3);
    rst_n = 1;
    @(negedge clk);
    // R3 R6 reset state
    chk(!req && !rd_req && !wr_req, "R3 reset flags", 64'({rd_req, wr_req, req}), 0);
    chk(!busy, "R6 reset busy", 64'(busy), 0);

    // R1 R9 R8 overflow while stopped
    for (int i = 0; i < 17; i++)
      dma_write({16'hB000 + 16'(2*i+1), 16'hB000 + 16'(2*i)});
    man_write(16'hDEAD);
    @(negedge clk);
    chk(!req && !busy, "R3 stopped holding data", 64'({req, busy}), 0);
    for (int i = 0; i < 16; i++)
      dma_read({16'hB000 + 16'(2*i+1), 16'hB000 + 16'(2*i)});
    dma_read({16'hB01F, 16'hB01F}); // R10 pad after empty

    // R10 short FIFO
    man_write(16'hA1); man_write(16'hA2); man_write(16'hA3);
    dma_read({16'hA2, 16'hA1});
    dma_read({16'hA3, 16'hA3});
    dma_read({16'hA3, 16'hA3});

    // R7 stop clears pad
    set_mode(2'd1);
    set_mode(2'd0);
    dma_read(32'h0);

    // R7 stop abandons queued manual data
    set_mode(2'd1);
    for (int i = 0; i < 4; i++) dma_write(32'h5555_5555);
    set_mode(2'd0);
    set_mode(2'd2);
    @(negedge clk);
    chk(wr_req && req, "R7 FIFO empty after stop (R2 write request)", 64'({wr_req, req}), 64'(2'b11));
    chk(!busy, "R6 idle when empty in write mode", 64'(busy), 0);

    // R2 R4 R11 drain with wrap and reload
    set_addr(19'h7FFFE);
    wr_exp_q.push_back({19'h7FFFE, 16'h0011});
    wr_exp_q.push_back({19'h00000, 16'h0022});
    wr_exp_q.push_back({19'h00400, 16'h0033});
    wr_exp_q.push_back({19'h00402, 16'h0044});
    wr_cyc_q.delete();
    dma_write(32'h0022_0011);
    dma_write(32'h0044_0033);
    @(negedge clk);
    chk(!wr_req && !req, "R2 request drops when FIFO filled", 64'({wr_req, req}), 0);
    chk(busy, "R6 busy with pending writes", 64'(busy), 1);
    for (int k = 0; k < 200 && wr_cyc_q.size() < 2; k++) @(negedge clk);
    set_addr(19'h00401); // bit 0 forced low
    idle(100);
    @(negedge clk);
    chk(wr_req && !busy, "R2 request back after drain", 64'({wr_req, busy}), 64'(2'b10));
    chk(wr_exp_q.size() == 0, "R5 all halfwords written", 64'(wr_exp_q.size()), 0);
    if (wr_cyc_q.size() >= 2)
      chk(wr_cyc_q[1] - wr_cyc_q[0] == 32, "R4 slot spacing", 64'(wr_cyc_q[1] - wr_cyc_q[0]), 32);
    else chk(0, "R4 slot spacing", 64'(wr_cyc_q.size()), 2);

    // R5 R4 read fill
    for (int k = 0; k < 48; k++) mem[32'h1000 + 2*k] = 16'hC000 + 16'(k);
    set_addr(19'h01000);
    set_mode(2'd3);
    start = cyc;
    @(negedge clk);
    chk(!rd_req && busy, "R5 read mode filling", 64'({rd_req, busy}), 64'(2'b01));
    for (int k = 0; k < 3000 && !rd_req; k++) @(negedge clk);
    el = cyc - start;
    chk(el >= 1020 && el <= 1030, "R4 fill time for 32 halfwords", 64'(el), 1024);
    chk(rd_req && req && !wr_req, "R5 read request when full", 64'({rd_req, req, wr_req}), 64'(3'b110));
    chk(!busy, "R6 idle when full", 64'(busy), 0);
    for (int i = 0; i < 16; i++)
      dma_read({16'hC000 + 16'(2*i+1), 16'hC000 + 16'(2*i)});
    for (int k = 0; k < 3000 && !rd_req; k++) @(negedge clk);
    dma_read({16'hC021, 16'hC020}); // R5 refill continues at next address
    set_mode(2'd0);
    @(negedge clk);
    chk(!req && !busy, "R3 stopped after read", 64'({req, busy}), 0);
    chk(rd_exp_q.size() == 0, "R10 all reads compared", 64'(rd_exp_q.size()), 0);
    summary();
  end
endmodule